// File: doc/BRIEF.md
# Reset Source Controller

This block gathers every reset request of the chip and turns them into one internal system reset and one open-drain drive on the bidirectional reset pin. The requests are a power-on indication, a qualified brownout indication, a watchdog request, a key-protected software request and the external reset pin itself, which is active low. When a reset starts, the block records a code that names the source, so firmware can find out after restart why the chip was reset.

The block runs on the slow clock. Power-on is an asynchronous input that reinitialises every flop in the block. The other sources are sampled by the state machine only while it is idle. Once a reset has started, the controller pulls the pin low for a minimum of 2^(N+1) clock cycles, where N is a 4-bit length field that software writes. It then releases the pin and holds the system reset until the synchronised pin reads high again. An external device can therefore lengthen the reset but never shorten it.

The state machine has three states. ST_IDLE has no reset active. ST_HOLD drives the pin low and counts out the minimum pulse. ST_RELEASE has stopped driving the pin and waits for it to read high. The transitions are:
- IDLE to HOLD on any accepted request, which also loads the timer and captures the cause.
- HOLD to RELEASE when the timer reaches zero.
- RELEASE to IDLE when the synchronised pin is high.
- Power-on forces HOLD from any state.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` and `nrst_pad_oe_o` are 1 and `cause_o` is 0 (power-up). The length field returns to its default N=2, so the pulse that follows power-on release is 8 cycles long.
- R2: After a reset starts, `nrst_pad_oe_o` is high for exactly 2^(N+1) consecutive clock cycles.
- R3: A write with `len_we_i` high stores `len_i` as N for every later reset: N=0 gives a 2-cycle pulse and N=3 gives 16 cycles.
- R4: After the pin drive ends, `sys_rst_o` stays high while the pin reads low. Once the pin returns high, `sys_rst_o` falls on the third clock edge, because of the two-flop synchroniser and the state register.
- R5: An external low pulse on the pin of any length, including a single cycle, starts a reset with `cause_o` = 4 (user) and a full minimum-length pin drive.
- R6: A high `bod_i` starts a reset with `cause_o` = 1 (brownout) only while `bod_rst_en_i` is 1. With the enable at 0, brownout has no effect.
- R7: A watchdog request `wdt_i` starts a reset with `cause_o` = 2 (watchdog).
- R8: A `sw_req_i` pulse starts a reset with `cause_o` = 3 (software) only when `sw_key_i` equals 8'hA5. With any other key it is ignored.
- R9: When several non-power-on requests arrive together, the cause code follows this priority: brownout, then watchdog, then software, then user.
- R10: Power-on overrides every other source. If another request is present at power-on release, `cause_o` still reads 0.
- R11: Requests that arrive while a reset is in progress are ignored, and `cause_o` keeps the code of the source that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| bod_i | input | 1 | Qualified brownout detection |
| bod_rst_en_i | input | 1 | Non-volatile enable for the brownout reset |
| wdt_i | input | 1 | Watchdog reset request |
| sw_req_i | input | 1 | Software reset request strobe |
| sw_key_i | input | 8 | Key that must accompany the software request |
| len_we_i | input | 1 | Write strobe for the pulse length field |
| len_i | input | 4 | Pulse length field N |
| nrst_pad_i | input | 1 | Sensed level of the reset pin |
| nrst_pad_oe_o | output | 1 | When 1, the pin is driven low (open drain) |
| sys_rst_o | output | 1 | Internal system reset, active high |
| cause_o | output | 3 | Code of the last reset source |

## Verification
The bench counts the pin-drive cycles for the default length and for two written lengths. An off-by-one in the down-counter shows up as a pulse one cycle short or one cycle long. It gives the pin a one-cycle external pulse and also a pulse held far beyond the minimum. A design that samples the pin without the synchroniser, or that leaves reset when its own drive ends, either misses the short pulse or releases the system while the pin is still low. It applies requests together, requests during an active reset, a wrong software key, and brownout with the enable cleared. A wrong priority encoder, a cause register that can be overwritten mid-reset, or a missing gate would each report the wrong code or reset when it should not. Finally, it holds a watchdog request across power-on release, which catches a design that lets another source overwrite the power-up code.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // Reset cause codes reported on cause_o
    typedef enum logic [2:0] {
        CAUSE_POWERUP  = 3'd0,
        CAUSE_BROWNOUT = 3'd1,
        CAUSE_WATCHDOG = 3'd2,
        CAUSE_SOFTWARE = 3'd3,
        CAUSE_USER     = 3'd4
    } cause_t;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2
    } state_t;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Reset value 0: the pin is treated as low until proven high
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge por_i) begin
                    if (por_i) chain_q[0] <= 1'b0;
                    else       chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge por_i) begin
                    if (por_i) chain_q[i] <= 1'b0;
                    else       chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_req_arb.sv
module rstc_req_arb
    import rstc_pkg::*;
#(
    parameter int          KEY_W  = 8,
    parameter logic [7:0]  SW_KEY = 8'hA5
) (
    input  logic             bod_i,
    input  logic             bod_rst_en_i,
    input  logic             wdt_i,
    input  logic             sw_req_i,
    input  logic [KEY_W-1:0] sw_key_i,
    input  logic             pin_low_i,
    output logic             req_o,
    output cause_t           cause_o
);
    logic bod_ok, sw_ok;

    assign bod_ok = bod_i & bod_rst_en_i;
    assign sw_ok  = sw_req_i & (sw_key_i == KEY_W'(SW_KEY));

    // Fixed priority: brownout, watchdog, software, user (R9)
    always_comb begin
        req_o   = 1'b1;
        cause_o = CAUSE_USER;
        if (bod_ok)         cause_o = CAUSE_BROWNOUT;
        else if (wdt_i)     cause_o = CAUSE_WATCHDOG;
        else if (sw_ok)     cause_o = CAUSE_SOFTWARE;
        else if (pin_low_i) cause_o = CAUSE_USER;
        else                req_o   = 1'b0;
    end
endmodule

// File: rtl/rstc_pulse_timer.sv
module rstc_pulse_timer #(
    parameter int LEN_W   = 4,
    parameter int DEF_LEN = 2
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             run_i,
    output logic             done_o
);
    localparam int CNT_W = (1 << LEN_W) + 1;

    logic [CNT_W-1:0] cnt_q;

    // Cycles minus one for a pulse of 2^(n+1) cycles
    function automatic logic [CNT_W-1:0] span(input logic [LEN_W-1:0] n);
        logic [LEN_W:0] sh;
        sh = {1'b0, n} + (LEN_W+1)'(1);
        return (CNT_W'(1) << sh) - CNT_W'(1);
    endfunction

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)                    cnt_q <= span(LEN_W'(DEF_LEN));
        else if (load_i)              cnt_q <= span(len_i);
        else if (run_i && cnt_q != 0) cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done_o = (cnt_q == '0);

    // R2: a fresh load never finishes on the next cycle
    p_load_not_done_r2: assert property (@(posedge clk) disable iff (por_i)
        load_i |=> !done_o);
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
    import rstc_pkg::*;
#(
    parameter int         LEN_W       = 4,
    parameter int         DEF_LEN     = 2,
    parameter int         KEY_W       = 8,
    parameter logic [7:0] SW_KEY      = 8'hA5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             bod_i,
    input  logic             bod_rst_en_i,
    input  logic             wdt_i,
    input  logic             sw_req_i,
    input  logic [KEY_W-1:0] sw_key_i,
    input  logic             len_we_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             nrst_pad_i,
    output logic             nrst_pad_oe_o,
    output logic             sys_rst_o,
    output logic [2:0]       cause_o
);
    state_t           state_q, state_d;
    cause_t           cause_q, arb_cause;
    logic [LEN_W-1:0] len_q;
    logic             pin_sync, arb_req, tmr_done, tmr_load;

    // Pin synchroniser
    rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_i (por_i),
        .d_i   (nrst_pad_i),
        .q_o   (pin_sync)
    );

    // Source arbitration
    rstc_req_arb #(.KEY_W(KEY_W), .SW_KEY(SW_KEY)) u_arb (
        .bod_i        (bod_i),
        .bod_rst_en_i (bod_rst_en_i),
        .wdt_i        (wdt_i),
        .sw_req_i     (sw_req_i),
        .sw_key_i     (sw_key_i),
        .pin_low_i    (~pin_sync),
        .req_o        (arb_req),
        .cause_o      (arb_cause)
    );

    // Minimum pulse timer
    rstc_pulse_timer #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_tmr (
        .clk    (clk),
        .por_i  (por_i),
        .load_i (tmr_load),
        .len_i  (len_q),
        .run_i  (state_q == ST_HOLD),
        .done_o (tmr_done)
    );

    // Length field
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)         len_q <= LEN_W'(DEF_LEN);
        else if (len_we_i) len_q <= len_i;
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arb_req) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                end
            end
            ST_HOLD:    if (tmr_done) state_d = ST_RELEASE;
            ST_RELEASE: if (pin_sync) state_d = ST_IDLE;
            default:    state_d = ST_HOLD;
        endcase
    end

    // State register; power-on forces HOLD with power-up cause (R1, R10)
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            state_q <= ST_HOLD;
            cause_q <= CAUSE_POWERUP;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && arb_req) cause_q <= arb_cause;
        end
    end

    // Outputs
    always_comb begin
        nrst_pad_oe_o = 1'b0;
        sys_rst_o     = 1'b1;
        unique case (state_q)
            ST_IDLE:    sys_rst_o     = 1'b0;
            ST_HOLD:    nrst_pad_oe_o = 1'b1;
            ST_RELEASE: ;
            default:    nrst_pad_oe_o = 1'b1;
        endcase
    end

    assign cause_o = cause_q;

    // R11: cause frozen while a reset is active
    p_cause_frozen_r11: assert property (@(posedge clk) disable iff (por_i)
        (state_q != ST_IDLE) |=> $stable(cause_q));

    // R2: pin drive is part of the system reset
    p_drive_in_reset_r2: assert property (@(posedge clk) disable iff (por_i)
        nrst_pad_oe_o |-> sys_rst_o);

    // R4: no leaving release while the pin still reads low
    p_wait_for_pin_r4: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_RELEASE && !pin_sync) |=> (state_q == ST_RELEASE));

    // R6: brownout alone with the enable cleared keeps the block idle
    p_bod_gated_r6: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_IDLE && !bod_rst_en_i && !wdt_i && !sw_req_i && pin_sync)
        |=> (state_q == ST_IDLE));

    // R2: the drive lasts until the timer expires
    p_hold_until_done_r2: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_HOLD && !tmr_done) |=> (state_q == ST_HOLD));
endmodule

// File: tb/sim_rst_source_ctrl.sv
`timescale 1ns/100ps
module sim_rst_source_ctrl;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       bod = 1'b0, bod_en = 1'b0, wdt = 1'b0, sw_req = 1'b0;
    logic [7:0] sw_key = 8'h00;
    logic       len_we = 1'b0;
    logic [3:0] len = 4'd0;
    logic       ext_low = 1'b0;
    logic       pad_oe, sys_rst;
    logic [2:0] cause;
    logic       pad;

    int errors = 0, checks = 0, cyc = 0;

    assign pad = ~(pad_oe | ext_low);

    always #2.5 clk = ~clk;

    rst_source_ctrl u0 (
        .clk(clk), .por_i(por), .bod_i(bod), .bod_rst_en_i(bod_en),
        .wdt_i(wdt), .sw_req_i(sw_req), .sw_key_i(sw_key),
        .len_we_i(len_we), .len_i(len), .nrst_pad_i(pad),
        .nrst_pad_oe_o(pad_oe), .sys_rst_o(sys_rst), .cause_o(cause)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges with the pin drive active
    task automatic measure(output int n);
        int w = 0;
        n = 0;
        while (!pad_oe && w < 50) begin @(negedge clk); w++; end
        while (pad_oe && n < 100000) begin n++; @(negedge clk); end
    endtask

    task automatic wait_idle(input string req);
        int w = 0;
        while (sys_rst && w < 200) begin @(negedge clk); w++; end
        check(!sys_rst, req, int'(sys_rst), 0);
    endtask

    task automatic set_len(input logic [3:0] n);
        len_we = 1'b1; len = n; @(negedge clk); len_we = 1'b0;
    endtask

    task automatic t_por();
        int n;
        repeat (4) @(negedge clk);
        check(sys_rst == 1'b1, "R1 sys_rst in por", int'(sys_rst), 1);
        check(pad_oe == 1'b1, "R1 pad_oe in por", int'(pad_oe), 1);
        check(cause == 3'd0, "R1 cause in por", int'(cause), 0);
        por = 1'b0;
        measure(n);
        check(n == 8, "R1 default pulse", n, 8);
        wait_idle("R1 leaves reset");
    endtask

    task automatic t_wdt();
        int n;
        wdt = 1'b1; @(negedge clk); wdt = 1'b0;
        measure(n);
        check(n == 8, "R2 watchdog pulse", n, 8);
        wait_idle("R7 idle");
        check(cause == 3'd2, "R7 cause", int'(cause), 2);
    endtask

    task automatic t_len();
        int n;
        set_len(4'd0);
        wdt = 1'b1; @(negedge clk); wdt = 1'b0;
        measure(n);
        check(n == 2, "R3 N=0 pulse", n, 2);
        wait_idle("R3 idle");
        set_len(4'd3);
        wdt = 1'b1; @(negedge clk); wdt = 1'b0;
        measure(n);
        check(n == 16, "R3 N=3 pulse", n, 16);
        wait_idle("R3 idle");
    endtask

    task automatic t_sw();
        int n; bit seen = 0;
        sw_req = 1'b1; sw_key = 8'h5A; @(negedge clk); sw_req = 1'b0;
        repeat (10) begin if (sys_rst) seen = 1; @(negedge clk); end
        check(!seen, "R8 wrong key ignored", int'(seen), 0);
        check(cause == 3'd2, "R8 cause kept", int'(cause), 2);
        sw_req = 1'b1; sw_key = 8'hA5; @(negedge clk); sw_req = 1'b0;
        measure(n);
        check(n == 16, "R8 sw pulse", n, 16);
        wait_idle("R8 idle");
        check(cause == 3'd3, "R8 cause", int'(cause), 3);
    endtask

    task automatic t_bod();
        int n; bit seen = 0;
        bod = 1'b1; bod_en = 1'b0;
        repeat (10) begin @(negedge clk); if (sys_rst) seen = 1; end
        check(!seen, "R6 gated off", int'(seen), 0);
        check(cause == 3'd3, "R6 cause kept", int'(cause), 3);
        bod_en = 1'b1; @(negedge clk); bod = 1'b0;
        measure(n);
        check(n == 16, "R6 bod pulse", n, 16);
        wait_idle("R6 idle");
        check(cause == 3'd1, "R6 cause", int'(cause), 1);
    endtask

    task automatic t_user_short();
        int n;
        ext_low = 1'b1; @(negedge clk); ext_low = 1'b0;
        measure(n);
        check(n == 16, "R5 stretched pulse", n, 16);
        wait_idle("R5 idle");
        check(cause == 3'd4, "R5 cause", int'(cause), 4);
    endtask

    task automatic t_user_long();
        int n = 0;
        set_len(4'd0);
        ext_low = 1'b1;
        repeat (30) @(negedge clk);
        check(sys_rst == 1'b1, "R4 held by pin", int'(sys_rst), 1);
        check(pad_oe == 1'b0, "R4 drive ended", int'(pad_oe), 0);
        ext_low = 1'b0;
        while (sys_rst && n < 20) begin @(negedge clk); n++; end
        check(n == 3, "R4 release latency", n, 3);
        check(cause == 3'd4, "R4 cause", int'(cause), 4);
    endtask

    task automatic t_prio();
        bod = 1'b1; wdt = 1'b1; sw_req = 1'b1; sw_key = 8'hA5;
        @(negedge clk);
        bod = 1'b0; wdt = 1'b0; sw_req = 1'b0;
        wait_idle("R9 idle");
        check(cause == 3'd1, "R9 bod wins", int'(cause), 1);
        wdt = 1'b1; sw_req = 1'b1; ext_low = 1'b1;
        @(negedge clk);
        wdt = 1'b0; sw_req = 1'b0; ext_low = 1'b0;
        wait_idle("R9 idle");
        check(cause == 3'd2, "R9 wdt wins", int'(cause), 2);
        sw_req = 1'b1; ext_low = 1'b1;
        @(negedge clk);
        sw_req = 1'b0; ext_low = 1'b0;
        wait_idle("R9 idle");
        check(cause == 3'd3, "R9 sw over user", int'(cause), 3);
    endtask

    task automatic t_busy();
        set_len(4'd3);
        sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
        repeat (3) @(negedge clk);
        wdt = 1'b1; bod = 1'b1; @(negedge clk); wdt = 1'b0; bod = 1'b0;
        check(cause == 3'd3, "R11 cause held mid-reset", int'(cause), 3);
        wait_idle("R11 idle");
        check(cause == 3'd3, "R11 cause after", int'(cause), 3);
    endtask

    task automatic t_por_over();
        int n;
        por = 1'b1; wdt = 1'b1;
        repeat (3) @(negedge clk);
        por = 1'b0;
        measure(n);
        wdt = 1'b0;
        check(n == 8, "R1 length back to default", n, 8);
        wait_idle("R10 idle");
        check(cause == 3'd0, "R10 power-up wins", int'(cause), 0);
    endtask

    initial begin
        t_por();
        t_wdt();
        t_len();
        t_sw();
        t_bod();
        t_user_short();
        t_user_long();
        t_prio();
        t_busy();
        t_por_over();
        summary();
    end
endmodule